// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block adds two 16-bit operands and a carry-in in pure combinational logic. The operands are split into four 4-bit groups. Inside each group, every carry is a flat sum of products of bit generate (a AND b) and bit propagate (a OR b) terms and the group's carry-in, so no carry ripples from one bit to the next. Each group also reports a group generate (a carry leaves the group whatever enters it) and a group propagate (every bit propagates).

A second-level lookahead unit takes the four group generate/propagate pairs and the external carry-in. It forms the carry into groups 1 to 3 and the final carry-out, each again as a flat sum of products. Sum bits are a XOR b XOR the incoming carry. The block has no state, so it can sit inside a datapath stage wherever an integer adder is needed.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned integers, for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned result `a_i + b_i + cin_i`.
- R3: A carry-in of 1 with `a_i` = 16'hFFFF and `b_i` = 0 passes through all four groups, giving `sum_o` = 0 and `cout_o` = 1. A group's generate OR propagate is 1 exactly when its slice produces a carry with a carry-in of 1.
- R4: A group whose slice produces a carry-out with a carry-in of 0 raises its group generate, and the carry into the next group is then 1 whatever its own carry-in is.
- R5: The carry into group k (bit position 4k) equals the carry out of the unsigned sum of the operand bits below 4k plus `cin_i`, at each of the boundaries 4, 8 and 12.
- R6: The outputs follow the inputs with no clock and no stored state. After any input change, the new sum is present once the logic settles, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach from the ports is a carry that one group generates and that must then pass through every group above it on propagate alone. Random operands rarely produce a long run of propagating bits. The stimulus therefore places all-ones runs that end exactly at the group boundaries 4, 8 and 12, and uses full-width all-ones operands with a carry-in. A random sweep then covers the general mix of generate and propagate patterns.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned MAX_W = 32;

  // carry out of position hi, from g/p[0..hi] and carry-in c, as a flat sum of products
  function automatic logic la_carry(input logic [MAX_W-1:0] p,
                                    input logic [MAX_W-1:0] g,
                                    input logic c,
                                    input int unsigned hi);
    logic term;
    logic acc;
    acc = c;
    for (int unsigned j = 0; j <= hi; j++) acc = acc & p[j];
    for (int unsigned j = 0; j <= hi; j++) begin
      term = g[j];
      for (int unsigned k = j + 1; k <= hi; k++) term = term & p[k];
      acc = acc | term;
    end
    return acc;
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GRP_W = 4
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             c_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             p_o,
  output logic             g_o
);
  import cla_pkg::*;

  logic [MAX_W-1:0] bit_g;
  logic [MAX_W-1:0] bit_p;
  logic [GRP_W-1:0] cy;

  always_comb begin
    bit_g = '0;
    bit_p = '0;
    bit_g[GRP_W-1:0] = a_i & b_i;
    bit_p[GRP_W-1:0] = a_i | b_i;
  end

  assign cy[0] = c_i;

  generate
    for (genvar i = 1; i < GRP_W; i++) begin : g_cy
      assign cy[i] = la_carry(bit_p, bit_g, c_i, i - 1);
    end
  endgenerate

  assign sum_o = a_i ^ b_i ^ cy;
  assign p_o   = &bit_p[GRP_W-1:0];
  assign g_o   = la_carry(bit_p, bit_g, 1'b0, GRP_W - 1);
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned NUM_GRP = 4
) (
  input  logic [NUM_GRP-1:0] p_i,
  input  logic [NUM_GRP-1:0] g_i,
  input  logic               c_i,
  output logic [NUM_GRP:0]   c_o
);
  import cla_pkg::*;

  logic [MAX_W-1:0] gp;
  logic [MAX_W-1:0] gg;

  always_comb begin
    gp = '0;
    gg = '0;
    gp[NUM_GRP-1:0] = p_i;
    gg[NUM_GRP-1:0] = g_i;
  end

  assign c_o[0] = c_i;

  generate
    for (genvar k = 1; k <= NUM_GRP; k++) begin : g_c
      assign c_o[k] = la_carry(gp, gg, c_i, k - 1);
    end
  endgenerate
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int unsigned NUM_GRP = DATA_W / GRP_W;

  logic [NUM_GRP-1:0] grp_p;
  logic [NUM_GRP-1:0] grp_g;
  logic [NUM_GRP:0]   grp_c;

  generate
    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
      cla_group #(.GRP_W(GRP_W)) u_grp (
        .a_i  (a_i[k*GRP_W +: GRP_W]),
        .b_i  (b_i[k*GRP_W +: GRP_W]),
        .c_i  (grp_c[k]),
        .sum_o(sum_o[k*GRP_W +: GRP_W]),
        .p_o  (grp_p[k]),
        .g_o  (grp_g[k])
      );
    end
  endgenerate

  cla_lookahead #(.NUM_GRP(NUM_GRP)) u_la (
    .p_i(grp_p),
    .g_i(grp_g),
    .c_i(cin_i),
    .c_o(grp_c)
  );

  assign cout_o = grp_c[NUM_GRP];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_W  = 4
) (
  input logic [DATA_W-1:0]        a_i,
  input logic [DATA_W-1:0]        b_i,
  input logic                     cin_i,
  input logic [DATA_W-1:0]        sum_o,
  input logic                     cout_o,
  input logic [DATA_W/GRP_W-1:0]  grp_p,
  input logic [DATA_W/GRP_W-1:0]  grp_g,
  input logic [DATA_W/GRP_W:0]    grp_c
);
  localparam int unsigned NUM_GRP = DATA_W / GRP_W;

  logic [DATA_W:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};

  always_comb begin
    logic [DATA_W:0] lo;
    logic [DATA_W:0] msk;
    logic [GRP_W:0]  s0;
    logic [GRP_W:0]  s1;
    p_sum_r1: assert (sum_o == ref_sum[DATA_W-1:0]);
    p_cout_r2: assert (cout_o == ref_sum[DATA_W]);
    for (int k = 1; k < NUM_GRP; k++) begin
      msk = ({{DATA_W{1'b0}}, 1'b1} << (k * GRP_W)) - 1'b1;
      lo  = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + {{DATA_W{1'b0}}, cin_i};
      p_grp_carry_r5: assert (grp_c[k] == lo[k*GRP_W]);
    end
    for (int k = 0; k < NUM_GRP; k++) begin
      s0 = {1'b0, a_i[k*GRP_W +: GRP_W]} + {1'b0, b_i[k*GRP_W +: GRP_W]};
      s1 = s0 + 1'b1;
      p_gen_r4: assert (grp_g[k] == s0[GRP_W]);
      p_prop_r3: assert ((grp_g[k] | grp_p[k]) == s1[GRP_W]);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o),
  .grp_p (grp_p),
  .grp_g (grp_g),
  .grp_c (grp_c)
);

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
  localparam int unsigned N_VEC = 14;
  localparam int unsigned N_RND = 3000;

  logic        clk;
  logic [15:0] a;
  logic [15:0] b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  int          n_chk;
  int          n_bad;
  int          cyc;

  // {a, b, cin, cout, sum}
  localparam logic [49:0] VEC [N_VEC] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
    {16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
    {16'h0FFF, 16'h0001, 1'b0, 1'b0, 16'h1000},
    {16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100},
    {16'h000F, 16'h0001, 1'b0, 1'b0, 16'h0010},
    {16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000},
    {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},
    {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF},
    {16'hAAAA, 16'h5555, 1'b1, 1'b1, 16'h0000},
    {16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'hFFFE},
    {16'h1234, 16'hEDCB, 1'b1, 1'b1, 16'h0000}
  };

  cla_adder u_cla_adder (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [16:0] exp);
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, {cout, sum}, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    a = '0; b = '0; cin = 1'b0;
    // R1 R2 table
    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      check("R1/R2 table", VEC[i][16:0]);
    end
    // R3: carry-in crosses all groups
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R3", 17'h10000);
    // R4: group 0 generates, groups 1..3 only propagate
    apply(16'hFFF8, 16'h0008, 1'b0);
    check("R4", 17'h10000);
    apply(16'h0F80, 16'h0080, 1'b0);
    check("R4", 17'h01000);
    // R5: boundaries 4, 8, 12 reached through carry-in only
    for (int k = 1; k < 4; k++) begin
      apply(16'((1 << (4 * k)) - 1), 16'h0000, 1'b1);
      check("R5", 17'(1 << (4 * k)));
    end
    // R6: change inputs mid-phase, no clock edge in between
    @(posedge clk);
    #2;
    a = 16'h00F0; b = 16'h0010; cin = 1'b0;
    #1;
    check("R6", 17'h00100);
    a = 16'h0001;
    #1;
    check("R6", 17'h00011);
    // R1 R2: exhaustive low byte sweep with upper bits all ones
    for (int v = 0; v < 512; v++) begin
      apply(16'hFF00 | 16'(v[7:0]), 16'(v[7:0] ^ 8'h5A), v[8]);
      check("R1/R2 sweep", 17'({1'b0, a} + {1'b0, b} + 17'(cin)));
    end
    // R1 R2: random full width
    for (int i = 0; i < N_RND; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check("R1/R2 random", 17'({1'b0, a} + {1'b0, b} + 17'(cin)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got=%0d exp=<100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule